// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block is the feedback path of a fractional-N frequency synthesizer. It divides a fast input clock (the oscillator being steered) by a programmable ratio of 16·N + A + F/13. A dual-modulus prescaler divides by 17 or by 16. A main count N sets how many prescaler cycles make one output period. A swallow count A sets how many of those cycles use the longer modulus. A modulo-13 accumulator adds the numerator F once per period. When the accumulator wraps, that period gets one extra input cycle, so over thirteen periods the ratio averages to the fractional value.

A second, independent divider turns the reference oscillator clock into the comparison clock `fr`. It divides by a programmable R. All settings arrive on parallel ports and are taken only at period boundaries. Out-of-range settings are forced to the nearest legal value and reported on `cfg_err`.

A period is sequenced by a small state machine. Its states are `PH_LOAD` (first cycle after reset, which takes the settings), `PH_SWALLOW` (divide-by-17 prescaler cycles while swallow cycles remain), `PH_PLAIN` (divide-by-16 cycles) and `PH_TAIL` (the last prescaler cycle, which is 17 long on an accumulator wrap). The transitions are:
- LOAD→SWALLOW or LOAD→PLAIN, chosen by whether A is zero.
- SWALLOW→PLAIN when the last swallow cycle ends.
- PLAIN→TAIL when one prescaler cycle remains.
- TAIL→SWALLOW or TAIL→PLAIN at the period end, which reloads all counts.

Top module: `frac_fb_divider`

## Requirements
- R1: The number of `clk_vco` cycles between successive `fp` pulses is 16·N + A + c. Here c is 1 when the accumulator sum (previous value + F) at that period's start is 13 or more, and 13 is then subtracted; otherwise c is 0. Over any 13 consecutive periods the total is 13·(16·N + A) + F.
- R2: `mod_ctl` is high for exactly 17·(A + c) input cycles of each period: the first A prescaler cycles, and the final prescaler cycle when c is 1.
- R3: In the input cycle right after an `fp` pulse, `mod_ctl` is 1 if A is non-zero and 0 if A is zero.
- R4: `fp` is high for exactly one input cycle, the last cycle of each period.
- R5: N, A and F are sampled only at a period start. A change during a period leaves that period's length unaltered and applies from the next period.
- R6: N below 18 is used as 18, and F of 13 or more is used as 12. A above N−3 is used as N−3; with N at least 18, every 4-bit A is already legal.
- R7: `fr` pulses high for one `clk_ref` cycle every R cycles. R below 3 is used as 3, and a new R takes effect from the next `fr` pulse.
- R8: `cfg_err` is a registered flag. One `clk_vco` cycle after the ports carry any illegal setting (N<18, A>N−3, F≥13, R<3) it reads 1; otherwise it reads 0.
- R9: While `rst_n` is low, `fp`, `mod_ctl` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock being divided |
| clk_ref | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| n_in | input | 10 | Main count N |
| a_in | input | 4 | Swallow count A |
| f_in | input | 4 | Fractional numerator F (denominator 13) |
| r_in | input | 7 | Reference ratio R |
| fp | output | 1 | Divided clock, one-cycle pulse per period |
| fr | output | 1 | Comparison clock, one-cycle pulse per R reference cycles |
| mod_ctl | output | 1 | High during divide-by-17 prescaler cycles |
| cfg_err | output | 1 | Illegal setting seen on the ports |

## Verification
The end of the swallow phase and the extra cycle from an accumulator wrap both fall on the long modulus, and the wrap always lands in the tail cycle that ends the period. That same cycle is also where the counts reload. The case is provoked with the largest swallow count (A=15, the most allowed at N=18) and F=12, which wraps on most periods. It is also provoked by changing N in the middle of a period. The outcome is judged per period from the length between `fp` pulses and the count of `mod_ctl` cycles, compared against an accumulator model run in the bench.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic [1:0] {
        PH_LOAD    = 2'd0,
        PH_SWALLOW = 2'd1,
        PH_PLAIN   = 2'd2,
        PH_TAIL    = 2'd3
    } phase_t;

endpackage

// File: rtl/fbdiv_frac_acc.sv
module fbdiv_frac_acc #(
    parameter int F_W    = 4,
    parameter int FRAC_Q = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [F_W-1:0] f_set,
    output logic           carry
);
    localparam int AW = $clog2(FRAC_Q);
    localparam int SW = ((AW > F_W) ? AW : F_W) + 1;

    logic [AW-1:0] acc_q;
    logic [SW-1:0] sum;
    logic          wrap;

    always_comb begin
        sum  = SW'(acc_q) + SW'(f_set);
        wrap = (sum >= SW'(FRAC_Q));
    end

    // One update per period start; carry holds for the whole period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            carry <= 1'b0;
        end else if (step) begin
            acc_q <= wrap ? AW'(sum - SW'(FRAC_Q)) : AW'(sum);
            carry <= wrap;
        end
    end

endmodule

// File: rtl/fbdiv_swallow_fsm.sv
module fbdiv_swallow_fsm
    import fbdiv_pkg::*;
#(
    parameter int N_W     = 10,
    parameter int A_W     = 4,
    parameter int PRE_MOD = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_set,
    input  logic [A_W-1:0] a_set,
    input  logic           carry,
    output logic           step,
    output logic           fp,
    output logic           mod_ctl
);
    localparam int PC_W = $clog2(PRE_MOD + 1);

    phase_t          phase_q, phase_d;
    logic [PC_W-1:0] pre_cnt;
    logic [N_W-1:0]  main_left;
    logic [A_W-1:0]  swal_left;
    logic            wide, last_in, end_per;

    always_comb begin
        wide    = (phase_q == PH_SWALLOW) || ((phase_q == PH_TAIL) && carry);
        last_in = wide ? (pre_cnt == PC_W'(PRE_MOD)) : (pre_cnt == PC_W'(PRE_MOD - 1));
        end_per = (phase_q == PH_TAIL) && last_in;
        step    = (phase_q == PH_LOAD) || end_per;
    end

    // Next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOAD:    phase_d = (a_set != '0) ? PH_SWALLOW : PH_PLAIN;
            PH_SWALLOW: if (last_in && swal_left == A_W'(1)) phase_d = PH_PLAIN;
            PH_PLAIN:   if (last_in && main_left == N_W'(2)) phase_d = PH_TAIL;
            PH_TAIL:    if (last_in) phase_d = (a_set != '0) ? PH_SWALLOW : PH_PLAIN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_LOAD;
        else        phase_q <= phase_d;
    end

    // Prescaler and period counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            main_left <= '0;
            swal_left <= '0;
        end else if (step) begin
            pre_cnt   <= '0;
            main_left <= n_set;
            swal_left <= a_set;
        end else if (last_in) begin
            pre_cnt   <= '0;
            main_left <= main_left - N_W'(1);
            if (swal_left != '0) swal_left <= swal_left - A_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PC_W'(1);
        end
    end

    // Outputs
    always_comb begin
        fp      = end_per;
        mod_ctl = wide;
    end

endmodule

// File: rtl/fbdiv_ref_div.sv
module fbdiv_ref_div #(
    parameter int R_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_set,
    output logic           fr
);
    logic [R_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == '0)  cnt <= r_set - R_W'(1);
        else                 cnt <= cnt - R_W'(1);
    end

    always_comb fr = (cnt == '0);

endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider #(
    parameter int N_W     = 10,
    parameter int A_W     = 4,
    parameter int F_W     = 4,
    parameter int R_W     = 7,
    parameter int PRE_MOD = 16,
    parameter int FRAC_Q  = 13,
    parameter int N_MIN   = 18,
    parameter int R_MIN   = 3,
    parameter int A_GAP   = 3
) (
    input  logic           clk_vco,
    input  logic           clk_ref,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    input  logic [F_W-1:0] f_in,
    input  logic [R_W-1:0] r_in,
    output logic           fp,
    output logic           fr,
    output logic           mod_ctl,
    output logic           cfg_err
);
    localparam logic [N_W-1:0] N_LO  = N_W'(N_MIN);
    localparam logic [F_W-1:0] F_TOP = F_W'(FRAC_Q);
    localparam logic [F_W-1:0] F_HI  = F_W'(FRAC_Q - 1);
    localparam logic [R_W-1:0] R_LO  = R_W'(R_MIN);

    logic           n_bad, a_bad, f_bad, r_bad;
    logic [N_W-1:0] n_set, a_lim;
    logic [A_W-1:0] a_set;
    logic [F_W-1:0] f_set;
    logic [R_W-1:0] r_set;
    logic           step, carry;

    always_comb begin
        n_bad = (n_in < N_LO);
        n_set = n_bad ? N_LO : n_in;
        a_lim = n_set - N_W'(A_GAP);
        a_bad = (N_W'(a_in) > a_lim);
        a_set = a_bad ? A_W'(a_lim) : a_in;
        f_bad = (f_in >= F_TOP);
        f_set = f_bad ? F_HI : f_in;
        r_bad = (r_in < R_LO);
        r_set = r_bad ? R_LO : r_in;
    end

    always_ff @(posedge clk_vco or negedge rst_n) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= n_bad | a_bad | f_bad | r_bad;
    end

    fbdiv_swallow_fsm #(.N_W(N_W), .A_W(A_W), .PRE_MOD(PRE_MOD)) u_fsm (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .n_set   (n_set),
        .a_set   (a_set),
        .carry   (carry),
        .step    (step),
        .fp      (fp),
        .mod_ctl (mod_ctl)
    );

    fbdiv_frac_acc #(.F_W(F_W), .FRAC_Q(FRAC_Q)) u_acc (
        .clk   (clk_vco),
        .rst_n (rst_n),
        .step  (step),
        .f_set (f_set),
        .carry (carry)
    );

    fbdiv_ref_div #(.R_W(R_W)) u_ref (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .r_set (r_set),
        .fr    (fr)
    );

endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker #(
    parameter int N_W    = 10,
    parameter int A_W    = 4,
    parameter int F_W    = 4,
    parameter int R_W    = 7,
    parameter int FRAC_Q = 13,
    parameter int N_MIN  = 18,
    parameter int R_MIN  = 3
) (
    input logic           clk_vco,
    input logic           clk_ref,
    input logic           rst_n,
    input logic [N_W-1:0] n_in,
    input logic [A_W-1:0] a_in,
    input logic [F_W-1:0] f_in,
    input logic [R_W-1:0] r_in,
    input logic           fp,
    input logic           fr,
    input logic           mod_ctl,
    input logic           cfg_err
);
    a_r4_fp_single: assert property (@(posedge clk_vco) disable iff (!rst_n)
        fp |=> !fp);

    a_r3_swallow_first: assert property (@(posedge clk_vco) disable iff (!rst_n)
        fp |=> (mod_ctl == ($past(a_in) != '0)));

    a_r7_fr_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fr |=> !fr);

    a_r8_err_follows: assert property (@(posedge clk_vco) disable iff (!rst_n)
        1'b1 |=> (cfg_err == (($past(n_in) < N_W'(N_MIN)) || ($past(f_in) >= F_W'(FRAC_Q))
                              || ($past(r_in) < R_W'(R_MIN)))));

endmodule

bind frac_fb_divider fbdiv_checker #(
    .N_W(N_W), .A_W(A_W), .F_W(F_W), .R_W(R_W),
    .FRAC_Q(FRAC_Q), .N_MIN(N_MIN), .R_MIN(R_MIN)
) u_fbdiv_checker (
    .clk_vco (clk_vco),
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .n_in    (n_in),
    .a_in    (a_in),
    .f_in    (f_in),
    .r_in    (r_in),
    .fp      (fp),
    .fr      (fr),
    .mod_ctl (mod_ctl),
    .cfg_err (cfg_err)
);

// File: tb/test_frac_fb_divider.sv
`timescale 1ns/1ps
module test_frac_fb_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] n_in = 10'd25;
    logic [3:0] a_in = 4'd3;
    logic [3:0] f_in = 4'd5;
    logic [6:0] r_in = 7'd10;
    logic       fp, fr, mod_ctl, cfg_err;

    always #2.5 clk = ~clk;

    frac_fb_divider i_frac_fb_divider (
        .clk_vco (clk), .clk_ref (clk), .rst_n (rst_n),
        .n_in (n_in), .a_in (a_in), .f_in (f_in), .r_in (r_in),
        .fp (fp), .fr (fr), .mod_ctl (mod_ctl), .cfg_err (cfg_err)
    );

    int n_checks = 0;
    int n_errs   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cl_n(input int v); return (v < 18) ? 18 : v; endfunction
    function automatic int cl_f(input int v); return (v >= 13) ? 12 : v; endfunction
    function automatic int cl_r(input int v); return (v < 3) ? 3 : v; endfunction

    // Period model and monitor
    int  m_acc, exp_len, exp_wide, a_used, per_cnt, wide_cnt, last_len, fp_seen;
    bit  have_p, prev_fp;
    int  fr_cnt, exp_r;
    bit  have_r;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_acc = cl_f(int'(f_in));
            have_p = 0; prev_fp = 0; per_cnt = 0; wide_cnt = 0;
            have_r = 0; fr_cnt = 0; fp_seen = 0;
        end else begin
            per_cnt++;
            if (mod_ctl) wide_cnt++;
            if (prev_fp) check(mod_ctl == (a_used != 0), "R3 first prescaler cycle", int'(mod_ctl), int'(a_used != 0));
            if (fp) begin
                check(!prev_fp, "R4 fp width", 2, 1);
                if (have_p) begin
                    check(per_cnt == exp_len, "R1 period length", per_cnt, exp_len);
                    check(wide_cnt == exp_wide, "R2 mod_ctl cycles", wide_cnt, exp_wide);
                end
                last_len = per_cnt;
                have_p = 1;
                begin
                    int n, f, s, c;
                    n = cl_n(int'(n_in));
                    f = cl_f(int'(f_in));
                    a_used = int'(a_in);
                    s = m_acc + f;
                    c = (s >= 13) ? 1 : 0;
                    m_acc = c ? s - 13 : s;
                    exp_len = 16 * n + a_used + c;
                    exp_wide = 17 * (a_used + c);
                end
                per_cnt = 0; wide_cnt = 0;
                fp_seen++;
            end
            prev_fp = fp;
            fr_cnt++;
            if (fr) begin
                if (have_r) check(fr_cnt == exp_r, "R7 fr spacing", fr_cnt, exp_r);
                exp_r = cl_r(int'(r_in));
                have_r = 1;
                fr_cnt = 0;
            end
        end
    end

    task automatic wait_fp();
        int k = fp_seen;
        while (fp_seen == k) @(posedge clk);
        #1;
    endtask

    task automatic sum13(input int n, input int a, input int f);
        int tot = 0;
        for (int i = 0; i < 13; i++) begin
            wait_fp();
            tot += last_len;
        end
        check(tot == 13 * (16 * n + a) + f, "R1 thirteen-period total", tot, 13 * (16 * n + a) + f);
    endtask

    localparam logic [17:0] VEC [4] = '{
        {10'd18, 4'd15, 4'd12},
        {10'd25, 4'd3,  4'd5 },
        {10'd40, 4'd0,  4'd1 },
        {10'd31, 4'd7,  4'd0 }
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++; n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        // R9: outputs quiet during reset
        repeat (3) @(negedge clk);
        check(fp == 0, "R9 fp in reset", int'(fp), 0);
        check(mod_ctl == 0, "R9 mod_ctl in reset", int'(mod_ctl), 0);
        check(cfg_err == 0, "R9 cfg_err in reset", int'(cfg_err), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_fp();

        for (int v = 0; v < 4; v++) begin
            n_in = VEC[v][17:8]; a_in = VEC[v][7:4]; f_in = VEC[v][3:0];
            wait_fp();
            sum13(int'(VEC[v][17:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]));
        end

        // R5: N changed mid-period; current period keeps old ratio
        n_in = 10'd25; a_in = 4'd3; f_in = 4'd5;
        wait_fp();
        wait_fp();
        repeat (40) @(posedge clk);
        #1 n_in = 10'd30;
        wait_fp();
        check(last_len == 403 || last_len == 404, "R5 period kept old N", last_len, 403);
        wait_fp();
        check(last_len == 483 || last_len == 484, "R5 next period new N", last_len, 483);

        // R6 / R8: illegal N and F clamp and flag
        n_in = 10'd5; f_in = 4'd14; a_in = 4'd15;
        @(posedge clk); @(negedge clk);
        check(cfg_err == 1, "R8 flag on illegal N/F", int'(cfg_err), 1);
        wait_fp();
        sum13(18, 15, 12);

        // R8 cleared, then R7 clamp of R
        n_in = 10'd20; f_in = 4'd2; a_in = 4'd1;
        @(posedge clk); @(negedge clk);
        check(cfg_err == 0, "R8 flag clears", int'(cfg_err), 0);
        #1 r_in = 7'd1;
        @(posedge clk); @(negedge clk);
        check(cfg_err == 1, "R8 flag on illegal R", int'(cfg_err), 1);
        repeat (40) @(posedge clk);
        #1 r_in = 7'd100;
        repeat (400) @(posedge clk);
        #1 r_in = 7'd3;
        wait_fp();
        wait_fp();

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule